// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit register bus. A down-counter is loaded from a programmable load register and decrements once per clock while the watchdog runs. The first time the counter passes zero, it sets an interrupt flag and reloads itself. If software has not cleared that flag by the next zero, the block asserts a reset request. That request stays asserted until the system reset clears it.

Software keeps the system alive in one of two ways. It can rewrite the load register, which restarts the count. It can also write the interrupt-clear register, which clears the flag and reloads the counter. A key register protects every other writable register. Writes land only while the key register holds the unlock value. Any other value written to the key register closes the block again.

Reads never change state. Software can read the live count, the raw flag, the masked flag, the lock state and four identification words.

Top module: `wdog_dual_stage`

## Requirements
- R1: After the synchronous active-low reset, the block reads back as follows. Load reads 0xFFFFFFFF. Count reads 0xFFFFFFFF. Control reads 0. Raw status, masked status and lock status read 0. `irq` and `wdog_rst` are low.
- R2: Writing 0x1ACCE551 to the key register (0xC00) opens the block, and writing any other value closes it. A read of 0xC00 returns 1 when closed and 0 when open. Reading it has no side effect.
- R3: While the block is closed, writes to load (0x000), control (0x008) and interrupt clear (0x00C) leave the stored load, control, flag and count unchanged.
- R4: A write to load (0x000) stores the value and restarts the count from it in the next cycle. A written value of 0 is stored as 1. Rewriting load before expiry keeps the flag clear.
- R5: The count (0x004) behaves as follows while control bit 0 is set. It decrements by one per clock. When it is at zero, the next clock sets the raw flag and reloads the count from the load value. From a load write of L, the flag therefore rises L+1 clocks after the write. While control bit 0 is clear, the count holds.
- R6: The reset request fires at the second zero if the flag is still set and control bit 1 is set. `wdog_rst` then rises 2(L+1) clocks after a load write of L. It stays high until system reset, even if control is later cleared.
- R7: With control bit 1 clear, `wdog_rst` never asserts, even when the counter expires with the flag set.
- R8: Bit 0 of raw status (0x010) is the flag. Bit 0 of masked status (0x014) and the `irq` output both equal the flag ANDed with control bit 0.
- R9: A write of any value to interrupt clear (0x00C) clears the flag and reloads the count from the load register.
- R10: The four words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC each carry one byte in bits 7:0, least significant byte first. Together these bytes form an identity that reads 0x141805 when masked to 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked first-stage interrupt |
| wdog_rst | output | 1 | Sticky second-stage reset request |

## Verification
The bench targets the exact cycle on which each stage fires, by sampling one clock before and on the expiry edge. A counter that is off by one, or that reloads to L-1, would show the flag or the reset a cycle early or late.

It writes the near-miss key 0x1ACCE550 and tries blocked writes to the clear register. A loose key compare, or a gate that misses the clear path, would let the flag drop while the block is closed.

It clears control after the reset request fires and runs with control bit 1 off. A request that is not sticky, or one that ignores its enable, would show up there.

A load write of 0 must read back as 1. This catches a counter that would wrap on the zero value.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the two-stage watchdog.
// Assumes a 12-bit byte address and 32-bit data on the register bus.
package wdog_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_LOAD   = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_COUNT  = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_CTRL   = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_RAW    = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_MASKED = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_KEY    = 12'hC00;
    localparam logic [BUS_AW-1:0] OFS_IDBASE = 12'hFE0;

    localparam logic [BUS_DW-1:0] OPEN_KEY = 32'h1ACCE551;
    localparam logic [BUS_DW-1:0] PART_ID  = 32'h00141805;
    localparam int unsigned       ID_WORDS = 4;

    // Control register fields: bit 0 run/interrupt enable, bit 1 reset enable.
    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
// Register file for the watchdog: key register, control, and load value.
// Produces a reload pulse and value for the counter, and a flag-clear pulse.
// Assumes at most one write per cycle. Reads are handled at the top.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              unlocked,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              reload,
    output logic [CNT_W-1:0]  reload_val,
    output logic              clr
);

    localparam logic [CNT_W-1:0] LOAD_ONE = CNT_W'(1);

    logic             wr_ok;
    logic             load_wr;
    logic [CNT_W-1:0] load_new;

    // Purpose: a load of zero would never expire cleanly, so clamp it to one.
    function automatic logic [CNT_W-1:0] clamp_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? LOAD_ONE : v;
    endfunction

    // Purpose: gate writes and derive the per-cycle write pulses.
    always_comb begin
        wr_ok      = bus_wr && unlocked;
        load_wr    = wr_ok && (bus_addr == OFS_LOAD);
        clr        = wr_ok && (bus_addr == OFS_CLEAR);
        load_new   = clamp_load(bus_wdata[CNT_W-1:0]);
        reload     = load_wr || clr;
        reload_val = load_wr ? load_new : load_q;
    end

    // Purpose: the key register is always writable; only the exact key opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b1;
        end else if (bus_wr && (bus_addr == OFS_KEY)) begin
            unlocked <= (bus_wdata == OPEN_KEY);
        end
    end

    // Purpose: hold the gated load value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '1;
        end else if (load_wr) begin
            load_q <= load_new;
        end
    end

    // Purpose: hold the gated control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok && (bus_addr == OFS_CTRL)) begin
            ctrl_q <= ctrl_t'(bus_wdata[1:0]);
        end
    end

endmodule

// File: rtl/wdog_counter.sv
// Down-counter of the watchdog. It reloads on a register pulse or after
// passing zero. It flags an expiry in the cycle the count sits at zero
// while running, unless a reload takes priority in that cycle.
module wdog_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    // Purpose: expiry is seen only when running and not overridden by a reload.
    always_comb begin
        expire = run && (cnt == '0) && !reload;
    end

    // Purpose: count down, reload on request or after zero, hold when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (reload) begin
            cnt <= reload_val;
        end else if (run) begin
            cnt <= (cnt == '0) ? load_q : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_escalate.sv
// Two-stage escalation. The first expiry sets the interrupt flag. An expiry
// with the flag still set raises a sticky reset request, if that is enabled.
// Assumes that clr and expire are never high together.
module wdog_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic rst_en,
    output logic flag,
    output logic rst_req
);

    // Purpose: raw interrupt flag, set by the first expiry and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end
    end

    // Purpose: sticky reset request on an expiry that finds the flag unserviced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else if (expire && flag && rst_en) begin
            rst_req <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_dual_stage.sv
// Top of the two-stage lockable watchdog. It connects the register file,
// counter and escalation logic, and decodes reads. Reads are combinational
// on the address and have no side effects.
module wdog_dual_stage
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);

    localparam int unsigned ID_SEL_W = $clog2(ID_WORDS);

    logic             unlocked;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic             reload;
    logic [CNT_W-1:0] reload_val;
    logic             clr;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             flag;
    logic [BUS_DW-1:0] id_word [ID_WORDS];

    wdog_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .unlocked   (unlocked),
        .ctrl_q     (ctrl_q),
        .load_q     (load_q),
        .reload     (reload),
        .reload_val (reload_val),
        .clr        (clr)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q.run),
        .reload     (reload),
        .reload_val (reload_val),
        .load_q     (load_q),
        .cnt        (cnt),
        .expire     (expire)
    );

    wdog_escalate esc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .clr     (clr),
        .rst_en  (ctrl_q.rst_en),
        .flag    (flag),
        .rst_req (wdog_rst)
    );

    // Identification words: one byte of the part identity per word.
    for (genvar gi = 0; gi < ID_WORDS; gi++) begin : g_id
        assign id_word[gi] = {24'h0, PART_ID[8*gi +: 8]};
    end

    // Purpose: masked interrupt output.
    always_comb begin
        irq = flag && ctrl_q.run;
    end

    // Purpose: read decode, with no side effects.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[BUS_AW-1:4] == OFS_IDBASE[BUS_AW-1:4]) begin
            bus_rdata = id_word[bus_addr[2 +: ID_SEL_W]];
        end else begin
            case (bus_addr)
                OFS_LOAD:   bus_rdata = BUS_DW'(load_q);
                OFS_COUNT:  bus_rdata = BUS_DW'(cnt);
                OFS_CTRL:   bus_rdata = BUS_DW'(ctrl_q);
                OFS_RAW:    bus_rdata = BUS_DW'(flag);
                OFS_MASKED: bus_rdata = BUS_DW'(irq);
                OFS_KEY:    bus_rdata = BUS_DW'(!unlocked);
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_dual_stage_chk.sv
// Property checker for the two-stage watchdog, bound to the top module.
// Observes internal state and the outputs; it drives nothing.
module wdog_dual_stage_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unlocked,
    input logic [CNT_W-1:0] load_q,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             rst_en,
    input logic             reload,
    input logic             flag,
    input logic             wdog_rst
);

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> wdog_rst);  // R6

    AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> ($past(flag) && $past(rst_en) && $past(cnt == '0)));  // R6

    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_en && !wdog_rst) |=> !wdog_rst);  // R7

    AST_LOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(load_q));  // R3

    AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt == '0) && $past(run)));  // R5

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(cnt));  // R5

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_q != '0);  // R4

endmodule

bind wdog_dual_stage wdog_dual_stage_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (unlocked),
    .load_q   (load_q),
    .cnt      (cnt),
    .run      (ctrl_q.run),
    .rst_en   (ctrl_q.rst_en),
    .reload   (reload),
    .flag     (flag),
    .wdog_rst (wdog_rst)
);

// File: tb/wdog_dual_stage_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random load/wait runs.
module wdog_dual_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdog_rst;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    wdog_dual_stage dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdog_rst  (wdog_rst)
    );

    // Expected model, from the requirements: k clocks after a load write of L.
    function automatic logic [31:0] exp_count(input int unsigned l, input int unsigned k);
        return l - (k % (l + 1));
    endfunction
    function automatic logic exp_flag(input int unsigned l, input int unsigned k);
        return k >= (l + 1);
    endfunction
    function automatic logic exp_rst(input int unsigned l, input int unsigned k, input logic en);
        return en && (k >= 2 * (l + 1));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clk(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] idv;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset();
        rd(12'h000, rv); chk("R1 load", rv, 32'hFFFFFFFF);
        rd(12'h004, rv); chk("R1 count", rv, 32'hFFFFFFFF);
        rd(12'h008, rv); chk("R1 ctrl", rv, 0);
        rd(12'h010, rv); chk("R1 raw", rv, 0);
        rd(12'h014, rv); chk("R1 masked", rv, 0);
        rd(12'hC00, rv); chk("R1 lock", rv, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wdog_rst", wdog_rst, 0);

        // R10 identification
        idv = 0;
        for (int i = 0; i < 4; i++) begin
            rd(12'hFE0 + 12'(4 * i), rv);
            idv |= {24'h0, rv[7:0]} << (8 * i);
        end
        chk("R10 id", idv & 32'h00FFFFFF, 32'h00141805);

        // R4 zero clamps to one; load restarts count even while stopped
        wr(12'h000, 0);
        rd(12'h000, rv); chk("R4 clamp", rv, 1);
        wr(12'h000, 7);
        rd(12'h004, rv); chk("R4 restart", rv, 7);
        // R5 hold while stopped, then decrement
        wait_clk(5);
        rd(12'h004, rv); chk("R5 hold", rv, 7);
        wr(12'h008, 1);
        wait_clk(3);
        rd(12'h004, rv); chk("R5 decrement", rv, 4);

        // R5 edge of first expiry, R8 masking, R9 clear
        do_reset();
        wr(12'h008, 1);
        wr(12'h000, 3);
        wait_clk(3);
        rd(12'h010, rv); chk("R5 raw before zero", rv, 0);
        wait_clk(1);
        rd(12'h010, rv); chk("R5 raw at expiry", rv, 1);
        rd(12'h004, rv); chk("R5 reload", rv, 3);
        chk("R8 irq on", irq, 1);
        wr(12'h008, 0);
        rd(12'h014, rv); chk("R8 masked off", rv, 0);
        chk("R8 irq off", irq, 0);
        rd(12'h010, rv); chk("R8 raw kept", rv, 1);
        wr(12'h008, 1);
        wr(12'h00C, 32'h0);
        rd(12'h010, rv); chk("R9 cleared", rv, 0);
        rd(12'h004, rv); chk("R9 reload", rv, 3);

        // R7 no reset when disabled
        do_reset();
        wr(12'h008, 1);
        wr(12'h000, 2);
        wait_clk(9);
        chk("R7 no reset", wdog_rst, 0);
        rd(12'h010, rv); chk("R7 flag set", rv, 1);

        // R6 exact cycle and stickiness
        do_reset();
        wr(12'h008, 3);
        wr(12'h000, 2);
        wait_clk(5);
        chk("R6 not yet", wdog_rst, 0);
        wait_clk(1);
        chk("R6 fires", wdog_rst, 1);
        wr(12'h008, 0);
        wait_clk(3);
        chk("R6 sticky", wdog_rst, 1);
        do_reset();
        chk("R1 reset clears request", wdog_rst, 0);

        // R4 keep-alive by rewriting load
        wr(12'h008, 1);
        wr(12'h000, 5);
        for (int i = 0; i < 6; i++) begin
            wait_clk(4);
            wr(12'h000, 5);
        end
        rd(12'h010, rv); chk("R4 keepalive", rv, 0);

        // R2 / R3 lock behaviour
        do_reset();
        wr(12'hC00, 1);
        rd(12'hC00, rv); chk("R2 locked", rv, 1);
        rd(12'hC00, rv); chk("R2 read no effect", rv, 1);
        wr(12'h000, 9);
        rd(12'h000, rv); chk("R3 load blocked", rv, 32'hFFFFFFFF);
        wr(12'h008, 3);
        rd(12'h008, rv); chk("R3 ctrl blocked", rv, 0);
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, rv); chk("R2 open", rv, 0);
        wr(12'h008, 1);
        wr(12'h000, 2);
        wait_clk(3);
        rd(12'h010, rv); chk("R5 flag before lock", rv, 1);
        wr(12'h008, 0);
        wr(12'hC00, 32'h1ACCE550);
        rd(12'hC00, rv); chk("R2 near key locks", rv, 1);
        wr(12'h00C, 0);
        rd(12'h010, rv); chk("R3 clear blocked", rv, 1);
        wr(12'hC00, 32'h1ACCE551);
        wr(12'h00C, 0);
        rd(12'h010, rv); chk("R9 clear after open", rv, 0);

        // Random: R5 R6 count/flag/reset versus k clocks after load
        for (int it = 0; it < 24; it++) begin
            int unsigned l, k;
            logic en;
            l  = 1 + ($urandom % 30);
            k  = $urandom % (2 * (l + 1) + 4);
            en = 1'($urandom % 2);
            do_reset();
            wr(12'h008, {30'h0, en, 1'b1});
            wr(12'h000, l);
            wait_clk(k);
            rd(12'h004, rv); chk("R5 rnd count", rv, exp_count(l, k));
            rd(12'h010, rv); chk("R5 rnd flag", rv, {31'h0, exp_flag(l, k)});
            chk("R6 rnd reset", wdog_rst, exp_rst(l, k, en));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule